// File: doc/BRIEF.md
# External Bus Transfer Sequencer

This block takes one internal access (address, direction, size and a burst-enable flag) and plays it out on an external bus as a series of transfers sized for the attached port, which may be 8, 16 or 32 bits wide. Each transfer presents an address and a two-bit size code with a one-clock start strobe. The block then waits for an acknowledge from the bus before it advances. An in-progress indicator frames the whole access.

A misaligned access is cut into naturally aligned pieces, and the size code of each piece gives that piece's own size. A piece wider than the port is played out as several beats. The address advances by the port width on each beat. With burst enabled, the size code keeps the piece size on every beat. With burst inhibited, it falls back to the port size after the first beat. Accesses flagged as SDRAM run the same bus cycles with the in-progress indicator held low. A 16-byte line request that is not 16-byte aligned is rejected with an error pulse.

Top module: `bus_xfer_seq`

## Requirements
- R1: Size codes are 00 longword, 01 byte, 10 word, 11 16-byte line. A misaligned request is split at each step into the largest naturally aligned piece (4, 2 or 1 bytes) that fits the bytes left, and the first beat of each piece carries that piece's code. For example, a longword at offset 1 becomes a byte at 1, a word at 2 and a byte at 4.
- R2: `req_ready` is high only while idle. A request is taken on a clock where `req_valid` and `req_ready` are both high. A request presented while busy does not alter the running sequence and is not queued.
- R3: With burst enabled, every beat of a piece carries the piece's size code, and the start strobe appears only on the first beat of each piece.
- R4: With burst inhibited, the first beat of a piece carries the piece code and each later beat carries the port code. The start strobe appears on every beat.
- R5: `bus_ts` is high for exactly one clock at the start of a transfer, with `bus_addr`, `bus_size` and `bus_write` already valid, and is low on the next clock.
- R6: `bus_tip` rises with the first start strobe of an access and stays high without a gap until the clock on which `done` is high. At that clock it is low, and it stays low while idle.
- R7: For a request with `req_sdram` high, `bus_tip` stays low throughout, while addresses, size codes and strobes are issued as for any other request.
- R8: `port_sel` 00 selects a 32-bit port, 01 an 8-bit port and 10 a 16-bit port, and the port code equals `port_sel`. A piece takes max(1, piece bytes / port bytes) beats, and `bus_addr` rises by the port width on each beat.
- R9: A line request whose address bits [3:0] are not zero gives a one-clock `err` pulse on the clock after it is taken. It starts no transfer and leaves the block idle.
- R10: `bus_ta` counts only on clocks after the strobe of a transfer. While it is low, the address and size hold. `done` is high for one clock, on the clock after the acknowledge of the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (R1 encoding) |
| req_burst | input | 1 | 1 = bursting allowed |
| req_sdram | input | 1 | Access targets SDRAM; in-progress indicator suppressed |
| port_sel | input | 2 | Port width select (R8 encoding) |
| bus_ta | input | 1 | Transfer acknowledge from the bus |
| req_ready | output | 1 | Idle and able to take a request |
| bus_addr | output | ADDR_W | Address of the current beat |
| bus_size | output | 2 | Size code of the current beat |
| bus_write | output | 1 | Direction of the current access |
| bus_ts | output | 1 | Transfer start strobe |
| bus_tip | output | 1 | Transfer in progress |
| done | output | 1 | Access completed pulse |
| err | output | 1 | Misaligned line request rejected |

## Verification
The hardest case to reach from the ports is a long multi-beat piece on a narrow port with acknowledges that arrive late. In that case the size code must fall back to the port code on exactly the right beats, and no in-progress gap may open between beats. The bench reaches it by driving `bus_ta` itself and inserting wait clocks on alternate vectors, including a 16-beat line on the 8-bit port. A second request held on `req_valid` for the whole of a running access checks that a busy sequencer ignores it, and that nothing starts once it is withdrawn.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_LINE = 2'b11;

  localparam int LINE_BYTES = 16;
  localparam int REM_W      = $clog2(LINE_BYTES) + 1;
  localparam int CNT_W      = $clog2(LINE_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} seq_state_t;

  // Bytes covered by a size code.
  function automatic logic [REM_W-1:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_bytes = REM_W'(1);
      SZ_WORD: size_bytes = REM_W'(2);
      SZ_LINE: size_bytes = REM_W'(LINE_BYTES);
      default: size_bytes = REM_W'(4);
    endcase
  endfunction

  // Port select doubles as the port's size code; the spare value maps to 32 bits.
  function automatic logic [1:0] port_code(input logic [1:0] sel);
    port_code = (sel == SZ_LINE) ? SZ_LONG : sel;
  endfunction

endpackage

// File: rtl/bxs_piece_calc.sv
module bxs_piece_calc
  import bxs_pkg::*;
(
  input  logic [1:0]       addr_lo,
  input  logic [REM_W-1:0] rem_bytes,
  input  logic             is_line,
  output logic [REM_W-1:0] piece_bytes,
  output logic [1:0]       piece_code
);

  // Largest naturally aligned chunk that fits the bytes still owed.
  always_comb begin
    if (is_line) begin
      piece_bytes = REM_W'(LINE_BYTES);
      piece_code  = SZ_LINE;
    end else if (addr_lo == 2'b00 && rem_bytes >= REM_W'(4)) begin
      piece_bytes = REM_W'(4);
      piece_code  = SZ_LONG;
    end else if (!addr_lo[0] && rem_bytes >= REM_W'(2)) begin
      piece_bytes = REM_W'(2);
      piece_code  = SZ_WORD;
    end else begin
      piece_bytes = REM_W'(1);
      piece_code  = SZ_BYTE;
    end
  end

endmodule

// File: rtl/bxs_beat_calc.sv
module bxs_beat_calc
  import bxs_pkg::*;
(
  input  logic [REM_W-1:0] piece_bytes,
  input  logic [REM_W-1:0] port_bytes,
  output logic [CNT_W-1:0] beats_m1
);

  logic [REM_W-1:0] quot;

  // Port widths are powers of two, so the division is a shift.
  always_comb begin
    case (port_bytes)
      REM_W'(1): quot = piece_bytes;
      REM_W'(2): quot = piece_bytes >> 1;
      default:   quot = piece_bytes >> 2;
    endcase
    if (quot == '0) quot = REM_W'(1);
    beats_m1 = CNT_W'(quot - REM_W'(1));
  end

endmodule

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq
  import bxs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_burst,
  input  logic              req_sdram,
  input  logic [1:0]        port_sel,
  input  logic              bus_ta,
  output logic              req_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_write,
  output logic              bus_ts,
  output logic              bus_tip,
  output logic              done,
  output logic              err
);

  seq_state_t        st;
  logic [ADDR_W-1:0] piece_base;
  logic [REM_W-1:0]  piece_len;
  logic [REM_W-1:0]  rem_left;
  logic [REM_W-1:0]  port_bytes_q;
  logic [CNT_W-1:0]  beats_left;
  logic [1:0]        piece_code_q;
  logic [1:0]        port_code_q;
  logic              burst_q;
  logic              line_q;
  logic              sdram_q;

  logic              idle;
  logic              req_line;
  logic              line_misaligned;
  logic [ADDR_W-1:0] next_base;
  logic [1:0]        calc_addr_lo;
  logic [REM_W-1:0]  calc_rem;
  logic              calc_line;
  logic [REM_W-1:0]  calc_port_bytes;
  logic [REM_W-1:0]  pc_bytes;
  logic [1:0]        pc_code;
  logic [CNT_W-1:0]  pc_beats_m1;

  assign idle            = (st == ST_IDLE);
  assign req_ready       = idle;
  assign req_line        = (req_size == SZ_LINE);
  assign line_misaligned = req_line && (req_addr[3:0] != 4'h0);
  assign next_base       = piece_base + ADDR_W'(piece_len);

  // One calculator serves both the first piece and every later one.
  assign calc_addr_lo    = idle ? req_addr[1:0] : next_base[1:0];
  assign calc_rem        = idle ? size_bytes(req_size) : rem_left;
  assign calc_line       = idle ? req_line : line_q;
  assign calc_port_bytes = idle ? size_bytes(port_code(port_sel)) : port_bytes_q;

  bxs_piece_calc u_piece (
    .addr_lo     (calc_addr_lo),
    .rem_bytes   (calc_rem),
    .is_line     (calc_line),
    .piece_bytes (pc_bytes),
    .piece_code  (pc_code)
  );

  bxs_beat_calc u_beats (
    .piece_bytes (pc_bytes),
    .port_bytes  (calc_port_bytes),
    .beats_m1    (pc_beats_m1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      bus_addr     <= '0;
      bus_size     <= SZ_LONG;
      bus_write    <= 1'b0;
      bus_ts       <= 1'b0;
      bus_tip      <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
      piece_base   <= '0;
      piece_len    <= '0;
      rem_left     <= '0;
      port_bytes_q <= REM_W'(4);
      beats_left   <= '0;
      piece_code_q <= SZ_LONG;
      port_code_q  <= SZ_LONG;
      burst_q      <= 1'b0;
      line_q       <= 1'b0;
      sdram_q      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (line_misaligned) begin
              err <= 1'b1;
            end else begin
              bus_addr     <= req_addr;
              bus_size     <= pc_code;
              bus_write    <= req_write;
              bus_ts       <= 1'b1;
              bus_tip      <= !req_sdram;
              piece_base   <= req_addr;
              piece_len    <= pc_bytes;
              piece_code_q <= pc_code;
              rem_left     <= calc_rem - pc_bytes;
              beats_left   <= pc_beats_m1;
              port_bytes_q <= calc_port_bytes;
              port_code_q  <= port_code(port_sel);
              burst_q      <= req_burst;
              line_q       <= req_line;
              sdram_q      <= req_sdram;
              st           <= ST_START;
            end
          end
        end
        ST_START: begin
          bus_ts <= 1'b0;
          st     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (bus_ta) begin
            if (beats_left != '0) begin
              bus_addr   <= bus_addr + ADDR_W'(port_bytes_q);
              beats_left <= beats_left - CNT_W'(1);
              bus_size   <= burst_q ? piece_code_q : port_code_q;
              if (!burst_q) begin
                bus_ts <= 1'b1;
                st     <= ST_START;
              end
            end else if (rem_left != '0) begin
              bus_addr     <= next_base;
              piece_base   <= next_base;
              piece_len    <= pc_bytes;
              piece_code_q <= pc_code;
              bus_size     <= pc_code;
              rem_left     <= rem_left - pc_bytes;
              beats_left   <= pc_beats_m1;
              bus_ts       <= 1'b1;
              st           <= ST_START;
            end else begin
              bus_tip <= 1'b0;
              done    <= 1'b1;
              st      <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bxs_checker.sv
module bxs_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_ts,
  input logic              bus_tip,
  input logic              bus_ta,
  input logic              done,
  input logic              err,
  input logic              req_ready,
  input logic              sdram_q,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size
);

  // R5
  a_r5_ts_one_clock: assert property (@(posedge clk) disable iff (rst)
    bus_ts |=> !bus_ts);

  // R2
  a_r2_strobe_not_ready: assert property (@(posedge clk) disable iff (rst)
    bus_ts |-> !req_ready);

  // R6
  a_r6_tip_falls_at_done: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_tip) |-> done);

  // R7
  a_r7_sdram_no_tip: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && sdram_q) |-> !bus_tip);

  // R9
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> (!bus_ts && !bus_tip && req_ready));

  // R10
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !bus_ts && !bus_ta) |=>
      ($stable(bus_addr) && $stable(bus_size) && !done));

endmodule

bind bus_xfer_seq bxs_checker #(.ADDR_W(ADDR_W)) u_bxs_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_ts    (bus_ts),
  .bus_tip   (bus_tip),
  .bus_ta    (bus_ta),
  .done      (done),
  .err       (err),
  .req_ready (req_ready),
  .sdram_q   (sdram_q),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size)
);

// File: tb/test_bus_xfer_seq.sv
module test_bus_xfer_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  typedef struct packed {
    logic [7:0]       off;
    logic [1:0]       size;
    logic             burst;
    logic [1:0]       port;
    logic [2:0]       n;
    logic [3:0][7:0]  eoff;
    logic [3:0][1:0]  ecode;
    logic [3:0]       ets;
  } vec_t;

  // Beat 0 is the rightmost element of eoff, ecode and ets.
  localparam vec_t VECS [13] = '{
    '{8'h01, 2'b00, 1'b0, 2'b00, 3'd3, {8'h00,8'h04,8'h02,8'h01}, {2'b00,2'b01,2'b10,2'b01}, 4'b0111}, // R1
    '{8'h00, 2'b00, 1'b0, 2'b01, 3'd4, {8'h03,8'h02,8'h01,8'h00}, {2'b01,2'b01,2'b01,2'b00}, 4'b1111}, // R4
    '{8'h00, 2'b00, 1'b1, 2'b01, 3'd4, {8'h03,8'h02,8'h01,8'h00}, {2'b00,2'b00,2'b00,2'b00}, 4'b0001}, // R3
    '{8'h02, 2'b10, 1'b0, 2'b01, 3'd2, {8'h00,8'h00,8'h03,8'h02}, {2'b00,2'b00,2'b01,2'b10}, 4'b0011}, // R4
    '{8'h03, 2'b10, 1'b0, 2'b00, 3'd2, {8'h00,8'h00,8'h04,8'h03}, {2'b00,2'b00,2'b01,2'b01}, 4'b0011}, // R1
    '{8'h00, 2'b00, 1'b0, 2'b00, 3'd1, {8'h00,8'h00,8'h00,8'h00}, {2'b00,2'b00,2'b00,2'b00}, 4'b0001}, // R8
    '{8'h07, 2'b01, 1'b0, 2'b10, 3'd1, {8'h00,8'h00,8'h00,8'h07}, {2'b00,2'b00,2'b00,2'b01}, 4'b0001}, // R8
    '{8'h03, 2'b00, 1'b0, 2'b10, 3'd3, {8'h00,8'h06,8'h04,8'h03}, {2'b00,2'b01,2'b10,2'b01}, 4'b0111}, // R1
    '{8'h10, 2'b11, 1'b1, 2'b00, 3'd4, {8'h1C,8'h18,8'h14,8'h10}, {2'b11,2'b11,2'b11,2'b11}, 4'b0001}, // R3
    '{8'h10, 2'b11, 1'b0, 2'b00, 3'd4, {8'h1C,8'h18,8'h14,8'h10}, {2'b00,2'b00,2'b00,2'b11}, 4'b1111}, // R4
    '{8'h02, 2'b00, 1'b0, 2'b01, 3'd4, {8'h05,8'h04,8'h03,8'h02}, {2'b01,2'b10,2'b01,2'b10}, 4'b1111}, // R1
    '{8'h00, 2'b10, 1'b1, 2'b00, 3'd1, {8'h00,8'h00,8'h00,8'h00}, {2'b00,2'b00,2'b00,2'b10}, 4'b0001}, // R8
    '{8'h00, 2'b10, 1'b1, 2'b01, 3'd2, {8'h00,8'h00,8'h01,8'h00}, {2'b00,2'b00,2'b10,2'b10}, 4'b0001}  // R3
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'b00;
  logic          req_burst = 1'b0;
  logic          req_sdram = 1'b0;
  logic [1:0]    port_sel = 2'b00;
  logic          bus_ta = 1'b0;
  logic          req_ready;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic          bus_write;
  logic          bus_ts;
  logic          bus_tip;
  logic          done;
  logic          err;

  bus_xfer_seq #(.ADDR_W(AW)) i_bus_xfer_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_size  (req_size),
    .req_burst (req_burst),
    .req_sdram (req_sdram),
    .port_sel  (port_sel),
    .bus_ta    (bus_ta),
    .req_ready (req_ready),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_write (bus_write),
    .bus_ts    (bus_ts),
    .bus_tip   (bus_tip),
    .done      (done),
    .err       (err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [AW-1:0] got_addr [16];
  logic [1:0]    got_code [16];
  logic          got_ts   [16];
  logic          got_wr   [16];
  int            got_n;
  int            tip_bad;
  logic          got_done;
  logic          lag_bad;

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 50000", cyc);
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  // Issue one request and play the bus side: acknowledge each data clock after ws wait clocks.
  task automatic run_req(input logic [AW-1:0] a, input logic [1:0] sz, input logic wr,
                         input logic bst, input logic [1:0] port, input logic sd,
                         input int ws, input logic hold);
    logic prev_ts;
    int   wcnt;
    int   since_ack;
    got_n = 0; tip_bad = 0; got_done = 1'b0; lag_bad = 1'b0;
    prev_ts = 1'b0; wcnt = 0; since_ack = -1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_burst = bst; port_sel = port; req_sdram = sd;
    @(negedge clk);
    if (hold) begin
      req_addr = 32'h0000_2005; req_size = 2'b01; req_burst = 1'b0; port_sel = 2'b01;
    end else begin
      req_valid = 1'b0;
    end
    for (int c = 0; c < 300; c++) begin
      bus_ta = 1'b0;
      if (done) begin
        got_done = 1'b1;
        if (since_ack != 1) lag_bad = 1'b1;
        if (bus_tip) tip_bad++;
        req_valid = 1'b0;
        break;
      end
      if (bus_tip != !sd) tip_bad++;
      if (bus_ts) begin
        prev_ts = 1'b1;
      end else if (!req_ready) begin
        if (wcnt < ws) begin
          wcnt++;
        end else begin
          bus_ta = 1'b1;
          if (got_n < 16) begin
            got_addr[got_n] = bus_addr;
            got_code[got_n] = bus_size;
            got_ts[got_n]   = prev_ts;
            got_wr[got_n]   = bus_write;
          end
          got_n++;
          prev_ts = 1'b0;
          wcnt = 0;
          since_ack = 0;
        end
      end
      if (since_ack >= 0) since_ack++;
      @(negedge clk);
    end
    bus_ta = 1'b0;
    req_valid = 1'b0;
  endtask

  initial begin
    vec_t v;
    logic wr;
    int   seen_ts;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(!bus_ts && !bus_tip && !done && !err, "R6",
        $sformatf("after reset ts=%0b tip=%0b done=%0b err=%0b expected all 0", bus_ts, bus_tip, done, err));
    chk(req_ready == 1'b1, "R2", $sformatf("after reset ready=%0b expected 1", req_ready));

    // vector walk
    for (int i = 0; i < 13; i++) begin
      v  = VECS[i];
      wr = i[0];
      run_req(32'h0000_1000 + AW'(v.off), v.size, wr, v.burst, v.port, 1'b0, i % 2, 1'b0);
      chk(got_done && !lag_bad, "R10",
          $sformatf("vec %0d done=%0b lag_bad=%0b expected done one clock after last ack", i, got_done, lag_bad));
      chk(got_n == int'(v.n), "R8", $sformatf("vec %0d beats=%0d expected %0d", i, got_n, v.n));
      chk(tip_bad == 0, "R6", $sformatf("vec %0d tip mismatches=%0d expected 0", i, tip_bad));
      for (int k = 0; k < int'(v.n) && k < got_n; k++) begin
        chk(got_addr[k] == 32'h0000_1000 + AW'(v.eoff[k]) && got_code[k] == v.ecode[k]
            && got_ts[k] == v.ets[k] && got_wr[k] == wr,
            v.burst ? "R3" : "R4",
            $sformatf("vec %0d beat %0d addr=%h code=%b ts=%0b wr=%0b expected addr=%h code=%b ts=%0b wr=%0b (R1 R5 R8)",
                      i, k, got_addr[k], got_code[k], got_ts[k], got_wr[k],
                      32'h0000_1000 + AW'(v.eoff[k]), v.ecode[k], v.ets[k], wr));
      end
    end

    // R4 R8: line on the 8-bit port, burst inhibited, one wait clock per beat
    run_req(32'h0000_1020, 2'b11, 1'b0, 1'b0, 2'b01, 1'b0, 1, 1'b0);
    chk(got_n == 16, "R8", $sformatf("line on 8-bit beats=%0d expected 16", got_n));
    for (int k = 0; k < 16 && k < got_n; k++) begin
      chk(got_addr[k] == 32'h0000_1020 + AW'(k) && got_code[k] == (k == 0 ? 2'b11 : 2'b01) && got_ts[k],
          "R4", $sformatf("line8 beat %0d addr=%h code=%b ts=%0b expected addr=%h code=%b ts=1",
                          k, got_addr[k], got_code[k], got_ts[k], 32'h0000_1020 + AW'(k),
                          (k == 0 ? 2'b11 : 2'b01)));
    end
    chk(tip_bad == 0, "R6", $sformatf("line8 tip mismatches=%0d expected 0", tip_bad));

    // R7: SDRAM flag keeps tip low but beats still run
    run_req(32'h0000_1000, 2'b00, 1'b1, 1'b0, 2'b01, 1'b1, 0, 1'b0);
    chk(tip_bad == 0, "R7", $sformatf("sdram tip mismatches=%0d expected 0", tip_bad));
    chk(got_n == 4 && got_done, "R7", $sformatf("sdram beats=%0d done=%0b expected 4 and 1", got_n, got_done));

    // R2: second request held during a busy access is ignored
    run_req(32'h0000_1001, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1, 1'b1);
    chk(got_n == 3 && got_addr[0] == 32'h1001 && got_addr[1] == 32'h1002 && got_addr[2] == 32'h1004, "R2",
        $sformatf("held request beats=%0d a0=%h a1=%h a2=%h expected 3 1001 1002 1004",
                  got_n, got_addr[0], got_addr[1], got_addr[2]));
    seen_ts = 0;
    repeat (4) begin
      @(negedge clk);
      if (bus_ts || !req_ready) seen_ts++;
    end
    chk(seen_ts == 0, "R2", $sformatf("activity after withdrawn request=%0d expected 0", seen_ts));

    // R9: misaligned line rejected
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_1014; req_size = 2'b11; req_burst = 1'b1;
    port_sel = 2'b00; req_sdram = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err && !bus_ts && !bus_tip && req_ready, "R9",
        $sformatf("misaligned line err=%0b ts=%0b tip=%0b ready=%0b expected 1 0 0 1", err, bus_ts, bus_tip, req_ready));
    seen_ts = 0;
    repeat (4) begin
      @(negedge clk);
      if (bus_ts || err || !req_ready) seen_ts++;
    end
    chk(seen_ts == 0, "R9", $sformatf("activity after error=%0d expected 0", seen_ts));

    // R5: strobe lasts one clock, attributes valid with it
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_1008; req_size = 2'b01; req_write = 1'b1;
    req_burst = 1'b0; port_sel = 2'b00;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_ts && bus_addr == 32'h1008 && bus_size == 2'b01 && bus_write, "R5",
        $sformatf("strobe clock ts=%0b addr=%h size=%b wr=%0b expected 1 1008 01 1", bus_ts, bus_addr, bus_size, bus_write));
    @(negedge clk);
    chk(!bus_ts && bus_tip, "R5", $sformatf("clock after strobe ts=%0b tip=%0b expected 0 1", bus_ts, bus_tip));
    bus_ta = 1'b1;
    @(negedge clk);
    bus_ta = 1'b0;
    chk(done && !bus_tip, "R10", $sformatf("done=%0b tip=%0b expected 1 0", done, bus_tip));
    @(negedge clk);
    chk(!done && req_ready, "R10", $sformatf("done=%0b ready=%0b expected 0 1", done, req_ready));

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

endmodule